// File: doc/BRIEF.md
# Timer Input Capture Unit

This block sits beside a free-running timer counter and watches one external capture pin. The pin is brought into the clock domain by a two-flop synchronizer and can optionally pass through a debounce filter. The unit then looks for a programmed transition on it. When the chosen transition occurs, the unit does one of two things. In capture mode it stores the counter value presented on its input bus and raises a sticky capture flag. In clear mode it sends a one-cycle reset request back to the counter and raises the same flag.

While the flag is set, further capture events are dropped and the stored value is not overwritten. Software clears the flag with a one-cycle clear strobe. A separate routing stage picks either the counter's time-out event or the capture event as its trigger source. It forwards the source as single-cycle pulses onto three trigger outputs, and each output has its own enable.

Top module: `tcap_unit`

## Requirements
- R1: After reset, cap_flag, cap_value, cap_irq, cnt_reset_req and trig_out are all 0.
- R2: With the debounce filter off, a pin transition held steady affects the outputs exactly 3 clock edges after the pin changes: two for the synchronizer and one for the output registers.
- R3: edge_sel selects the transition: 2'b00 falling, 2'b01 rising, 2'b10 both, 2'b11 none.
- R4: While cap_en is 0 the pin has no effect. No flag, no stored value, no reset request and no capture-sourced trigger result from it.
- R5: With func_sel = 0 (capture), a matching transition loads timer_count into cap_value and sets cap_flag.
- R6: With func_sel = 1 (clear), a matching transition sets cap_flag, pulses cnt_reset_req high for exactly one cycle, and leaves cap_value unchanged.
- R7: A matching transition while cap_flag is already 1 leaves cap_value unchanged and the flag set.
- R8: A one-cycle flag_clr clears cap_flag. If a flag-setting event lands on the same edge, the flag ends up set.
- R9: cap_irq is 1 exactly while cap_flag is 1 and cap_irq_en is 1.
- R10: With dbnc_en = 1, the filter accepts a new level only after 3 consecutive identical synchronized samples. A change lasting 2 cycles is ignored, and the latency from a pin change to the outputs becomes 6 edges.
- R11: trig_src_sel chooses the timer time-out event (0) or the capture event (1). Bit i of trig_en gates trig_out[i]. Each trigger output is a single-cycle pulse one edge after the source rises, even when the source stays high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cap_pin | input | 1 | Asynchronous external capture pin |
| cap_en | input | 1 | Enables the pin path |
| edge_sel | input | 2 | Transition select (R3 encoding) |
| func_sel | input | 1 | 0 = store count, 1 = clear counter |
| dbnc_en | input | 1 | Use the debounced level for edge detection |
| cap_irq_en | input | 1 | Capture interrupt enable |
| flag_clr | input | 1 | Write-one-to-clear strobe for cap_flag |
| timer_count | input | CNT_W | Current timer counter value |
| timeout_evt | input | 1 | Timer time-out event |
| trig_src_sel | input | 1 | Trigger source: 0 time-out, 1 capture |
| trig_en | input | NUM_TRIG | Per-output trigger enables |
| cap_value | output | CNT_W | Stored capture value |
| cap_flag | output | 1 | Sticky capture flag |
| cap_irq | output | 1 | Capture interrupt |
| cnt_reset_req | output | 1 | One-cycle reset request to the counter |
| trig_out | output | NUM_TRIG | Trigger pulses to downstream consumers |

## Verification
The bench builds the unit with its defaults: a 24-bit count, a two-stage synchronizer, a three-sample filter and three trigger outputs. These values keep the latencies short enough to check on the exact edge.

A full sweep covers the following combinations:
- filter on and off
- cap_en
- function select
- all four edge codes
- rising and falling pin transitions

Each case is checked one cycle before and one cycle after the predicted edge. This brings every edge code, the disabled path and both functions within reach of a single loop.

Directed sequences then cover the following cases:
- overrun
- clear colliding with a set
- glitches shorter and longer than the filter window
- a held time-out source feeding the trigger router

// File: rtl/tcap_pkg.sv
package tcap_pkg;

    typedef enum logic [1:0] {
        EDGE_FALL = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_BOTH = 2'b10,
        EDGE_NONE = 2'b11
    } edge_mode_e;

    typedef enum logic {
        FN_STORE = 1'b0,
        FN_CLEAR = 1'b1
    } cap_func_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_evt_t;

    function automatic logic edge_match(edge_mode_e mode, edge_evt_t ev);
        case (mode)
            EDGE_FALL: return ev.fall;
            EDGE_RISE: return ev.rise;
            EDGE_BOTH: return ev.rise | ev.fall;
            default:   return 1'b0;
        endcase
    endfunction

endpackage

// File: rtl/tcap_pin_cond.sv
module tcap_pin_cond #(
    parameter int SYNC_STAGES = 2,
    parameter int DB_SAMPLES  = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    input  logic dbnc_en,
    output logic level
);
    localparam int DB_CW = $clog2(DB_SAMPLES + 1);
    localparam logic [DB_CW-1:0] DB_LAST = DB_CW'(DB_SAMPLES - 1);

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   sync_lvl;
    logic                   db_lvl;
    logic [DB_CW-1:0]       db_cnt;

    always_ff @(posedge clk) begin
        if (rst) sync_q <= '0;
        else     sync_q <= {sync_q[SYNC_STAGES-2:0], pin};
    end

    assign sync_lvl = sync_q[SYNC_STAGES-1];

    // a differing level must be seen DB_SAMPLES times in a row
    always_ff @(posedge clk) begin
        if (rst) begin
            db_lvl <= 1'b0;
            db_cnt <= '0;
        end else if (sync_lvl == db_lvl) begin
            db_cnt <= '0;
        end else if (db_cnt == DB_LAST) begin
            db_lvl <= sync_lvl;
            db_cnt <= '0;
        end else begin
            db_cnt <= db_cnt + 1'b1;
        end
    end

    assign level = dbnc_en ? db_lvl : sync_lvl;

endmodule

// File: rtl/tcap_edge_det.sv
module tcap_edge_det
    import tcap_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       level,
    input  logic       enable,
    input  edge_mode_e mode,
    output logic       hit
);
    logic      prev_q;
    edge_evt_t ev;

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= level;
    end

    always_comb begin
        ev.rise = level & ~prev_q;
        ev.fall = ~level & prev_q;
    end

    assign hit = enable & edge_match(mode, ev);

endmodule

// File: rtl/tcap_trig_route.sv
module tcap_trig_route #(
    parameter int NUM_TRIG = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                timeout_evt,
    input  logic                cap_evt,
    input  logic                src_sel,
    input  logic [NUM_TRIG-1:0] trig_en,
    output logic [NUM_TRIG-1:0] trig_out
);
    logic src, src_q, src_rise;

    assign src = src_sel ? cap_evt : timeout_evt;

    always_ff @(posedge clk) begin
        if (rst) src_q <= 1'b0;
        else     src_q <= src;
    end

    assign src_rise = src & ~src_q;

    for (genvar i = 0; i < NUM_TRIG; i++) begin : g_lane
        always_ff @(posedge clk) begin
            if (rst) trig_out[i] <= 1'b0;
            else     trig_out[i] <= src_rise & trig_en[i];
        end
    end

endmodule

// File: rtl/tcap_unit.sv
module tcap_unit
    import tcap_pkg::*;
#(
    parameter int CNT_W       = 24,
    parameter int SYNC_STAGES = 2,
    parameter int DB_SAMPLES  = 3,
    parameter int NUM_TRIG    = 3
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cap_pin,
    input  logic                cap_en,
    input  logic [1:0]          edge_sel,
    input  logic                func_sel,
    input  logic                dbnc_en,
    input  logic                cap_irq_en,
    input  logic                flag_clr,
    input  logic [CNT_W-1:0]    timer_count,
    input  logic                timeout_evt,
    input  logic                trig_src_sel,
    input  logic [NUM_TRIG-1:0] trig_en,
    output logic [CNT_W-1:0]    cap_value,
    output logic                cap_flag,
    output logic                cap_irq,
    output logic                cnt_reset_req,
    output logic [NUM_TRIG-1:0] trig_out
);
    logic      pin_lvl;
    logic      edge_hit;
    cap_func_e func;

    assign func = cap_func_e'(func_sel);

    tcap_pin_cond #(
        .SYNC_STAGES(SYNC_STAGES),
        .DB_SAMPLES (DB_SAMPLES)
    ) u_pin (
        .clk    (clk),
        .rst    (rst),
        .pin    (cap_pin),
        .dbnc_en(dbnc_en),
        .level  (pin_lvl)
    );

    tcap_edge_det u_edge (
        .clk   (clk),
        .rst   (rst),
        .level (pin_lvl),
        .enable(cap_en),
        .mode  (edge_mode_e'(edge_sel)),
        .hit   (edge_hit)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            cap_value     <= '0;
            cap_flag      <= 1'b0;
            cnt_reset_req <= 1'b0;
        end else begin
            cnt_reset_req <= edge_hit && (func == FN_CLEAR);
            if (edge_hit && func == FN_STORE && !cap_flag)
                cap_value <= timer_count;
            if (edge_hit)
                cap_flag <= 1'b1;
            else if (flag_clr)
                cap_flag <= 1'b0;
        end
    end

    assign cap_irq = cap_flag & cap_irq_en;

    tcap_trig_route #(.NUM_TRIG(NUM_TRIG)) u_route (
        .clk        (clk),
        .rst        (rst),
        .timeout_evt(timeout_evt),
        .cap_evt    (edge_hit),
        .src_sel    (trig_src_sel),
        .trig_en    (trig_en),
        .trig_out   (trig_out)
    );

endmodule

// File: rtl/tcap_unit_chk.sv
module tcap_unit_chk #(
    parameter int CNT_W    = 24,
    parameter int NUM_TRIG = 3
) (
    input logic                clk,
    input logic                rst,
    input logic                cap_en,
    input logic                flag_clr,
    input logic [CNT_W-1:0]    cap_value,
    input logic                cap_flag,
    input logic                cnt_reset_req,
    input logic [NUM_TRIG-1:0] trig_out
);
    // R4
    pin_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (!cap_en && !cap_flag) |=> !cap_flag);

    // R5
    load_with_flag_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(cap_value) |-> $rose(cap_flag));

    // R6
    reset_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_reset_req |=> !cnt_reset_req);

    // R6
    reset_sets_flag_chk: assert property (@(posedge clk) disable iff (rst)
        cnt_reset_req |-> cap_flag);

    // R7
    overrun_hold_chk: assert property (@(posedge clk) disable iff (rst)
        cap_flag |=> $stable(cap_value));

    // R8
    clear_cause_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(cap_flag) |-> $past(flag_clr));

    // R11
    trig_single_chk: assert property (@(posedge clk) disable iff (rst)
        (trig_out & $past(trig_out)) == '0);

endmodule

bind tcap_unit tcap_unit_chk #(.CNT_W(CNT_W), .NUM_TRIG(NUM_TRIG)) u_chk (
    .clk          (clk),
    .rst          (rst),
    .cap_en       (cap_en),
    .flag_clr     (flag_clr),
    .cap_value    (cap_value),
    .cap_flag     (cap_flag),
    .cnt_reset_req(cnt_reset_req),
    .trig_out     (trig_out)
);

// File: tb/tcap_unit_bench.sv
module tcap_unit_bench;
    localparam int CNT_W = 24;
    localparam int NT    = 3;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             cap_pin = 1'b0;
    logic             cap_en = 1'b0;
    logic [1:0]       edge_sel = 2'b00;
    logic             func_sel = 1'b0;
    logic             dbnc_en = 1'b0;
    logic             cap_irq_en = 1'b0;
    logic             flag_clr = 1'b0;
    logic [CNT_W-1:0] timer_count = '0;
    logic             timeout_evt = 1'b0;
    logic             trig_src_sel = 1'b1;
    logic [NT-1:0]    trig_en = '0;
    logic [CNT_W-1:0] cap_value;
    logic             cap_flag, cap_irq, cnt_reset_req;
    logic [NT-1:0]    trig_out;

    int n_cmp = 0;
    int n_bad = 0;
    int cycles = 0;
    logic [CNT_W-1:0] exp_val = '0;

    always #10 clk = ~clk;

    tcap_unit u_tcap_unit (
        .clk(clk), .rst(rst), .cap_pin(cap_pin), .cap_en(cap_en),
        .edge_sel(edge_sel), .func_sel(func_sel), .dbnc_en(dbnc_en),
        .cap_irq_en(cap_irq_en), .flag_clr(flag_clr), .timer_count(timer_count),
        .timeout_evt(timeout_evt), .trig_src_sel(trig_src_sel), .trig_en(trig_en),
        .cap_value(cap_value), .cap_flag(cap_flag), .cap_irq(cap_irq),
        .cnt_reset_req(cnt_reset_req), .trig_out(trig_out)
    );

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            n_bad = n_bad + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 50000", cycles);
            summary();
        end
    end

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_flag();
        flag_clr = 1'b1;
        tick(1);
        flag_clr = 1'b0;
    endtask

    initial begin
        tick(3);
        rst = 1'b0;
        tick(1);
        // R1 reset state
        check("R1 flag", 32'(cap_flag), 0);
        check("R1 value", 32'(cap_value), 0);
        check("R1 irq", 32'(cap_irq), 0);
        check("R1 rstreq", 32'(cnt_reset_req), 0);
        check("R1 trig", 32'(trig_out), 0);

        // Sweep: R2 R3 R4 R5 R6 R9 R10 R11
        for (int idx = 0; idx < 64; idx++) begin
            automatic logic st   = idx[0];
            automatic logic [1:0] es = idx[2:1];
            automatic logic fs   = idx[3];
            automatic logic ce   = idx[4];
            automatic logic db   = idx[5];
            automatic logic rise = ~st;
            automatic logic hit;
            automatic int   lat;
            automatic logic [NT-1:0] te = NT'((idx * 5 + 3) % 8);
            cap_en = 1'b0;
            cap_pin = st;
            tick(10);
            clear_flag();
            cap_en = ce; edge_sel = es; func_sel = fs; dbnc_en = db;
            cap_irq_en = idx[1] ^ idx[3];
            trig_src_sel = 1'b1; trig_en = te;
            timer_count = CNT_W'(24'h100000 + idx * 37);
            tick(1);
            hit = ce && ((es == 2'b10) || (es == 2'b01 && rise) || (es == 2'b00 && !rise));
            lat = db ? 6 : 3;
            cap_pin = ~st;
            tick(lat - 1);
            check("R2/R10 early flag", 32'(cap_flag), 0);
            check("R2/R10 early trig", 32'(trig_out), 0);
            tick(1);
            if (hit && !fs) exp_val = timer_count;
            check("R3/R4 flag", 32'(cap_flag), 32'(hit));
            check("R5/R6 value", 32'(cap_value), 32'(exp_val));
            check("R6 rstreq", 32'(cnt_reset_req), 32'(hit && fs));
            check("R9 irq", 32'(cap_irq), 32'(hit && cap_irq_en));
            check("R11 trig", 32'(trig_out), hit ? 32'(te) : 0);
            tick(1);
            check("R6 rstreq pulse", 32'(cnt_reset_req), 0);
            check("R11 trig pulse", 32'(trig_out), 0);
        end

        // R7 overrun
        cap_en = 1'b1; edge_sel = 2'b10; func_sel = 1'b0; dbnc_en = 1'b0;
        cap_irq_en = 1'b1; trig_en = '0;
        tick(4); clear_flag();
        timer_count = 24'hABCDE1; cap_pin = ~cap_pin; tick(3);
        check("R5 value A", 32'(cap_value), 32'h00ABCDE1);
        timer_count = 24'h123456; cap_pin = ~cap_pin; tick(3);
        check("R7 value kept", 32'(cap_value), 32'h00ABCDE1);
        check("R7 flag kept", 32'(cap_flag), 1);
        clear_flag();
        check("R8 cleared", 32'(cap_flag), 0);
        check("R9 irq low", 32'(cap_irq), 0);
        timer_count = 24'h0F0F0F; cap_pin = ~cap_pin; tick(3);
        check("R5 value C", 32'(cap_value), 32'h000F0F0F);

        // R8 set and clear on the same edge
        clear_flag();
        timer_count = 24'h777001; cap_pin = ~cap_pin; tick(2);
        flag_clr = 1'b1; tick(1); flag_clr = 1'b0;
        check("R8 set wins", 32'(cap_flag), 1);
        check("R8 value", 32'(cap_value), 32'h00777001);

        // R10 glitch rejection with filter on
        dbnc_en = 1'b1; tick(8); clear_flag();
        cap_pin = ~cap_pin; tick(2); cap_pin = ~cap_pin; tick(10);
        check("R10 glitch2 ignored", 32'(cap_flag), 0);
        cap_pin = ~cap_pin; tick(3); cap_pin = ~cap_pin; tick(12);
        check("R10 hold3 accepted", 32'(cap_flag), 1);
        // filter off: one-cycle glitch is seen
        dbnc_en = 1'b0; tick(8); clear_flag();
        cap_pin = ~cap_pin; tick(1); cap_pin = ~cap_pin; tick(6);
        check("R2 glitch seen", 32'(cap_flag), 1);

        // R11 time-out source held high
        cap_en = 1'b0; trig_src_sel = 1'b0; trig_en = 3'b110;
        tick(2);
        timeout_evt = 1'b1; tick(1);
        check("R11 timeout trig", 32'(trig_out), 32'b110);
        tick(1);
        check("R11 held source", 32'(trig_out), 0);
        tick(2); timeout_evt = 1'b0; tick(1);
        // capture edge does not trigger when source is time-out
        cap_en = 1'b1; clear_flag();
        cap_pin = ~cap_pin; tick(3);
        check("R11 src select", 32'(trig_out), 0);
        check("R11 flag still set", 32'(cap_flag), 1);
        summary();
    end
endmodule